// File: doc/BRIEF.md
# Floating-Point Conditional Flow Resolver

This block settles where execution goes after one of the three conditional control-flow operations of a floating-point unit: a conditional branch, a decrement-and-loop, and a trap-on-condition. A separate predicate evaluator supplies the condition outcome. The instruction fetch path supplies the instruction address, the words that follow the opcode, a size bit and a trap mode field. The block then returns the next program counter, and also the rewritten loop counter when a loop is resolved.

A trap-on-condition request becomes a trap request instead of a PC write. That trap request carries a fixed vector number and a return address. If the caller flags an unordered-comparison exception, every architectural update is withheld. Undefined trap modes, and the reserved operation kind, raise an illegal-instruction indication.

Requests are accepted one per cycle and answered exactly one cycle later through registered outputs. There is no handshake. The caller builds the exception frame and fetches memory.

Top module: `fp_cond_flow`

## Requirements
- R1: While reset is applied, and in any cycle with no response, `rsp_valid`, `pc_we`, `cnt_we`, `trap_req` and `illegal` are all low.
- R2: A request sampled with `req_valid` high on a rising edge produces `rsp_valid` high after that same edge, for one cycle. Operation kinds are encoded as 0 = branch, 1 = loop, 2 = trap, 3 = reserved.
- R3: Branch with `long_sel` = 0: the displacement is `disp_hi`, sign-extended from 16 bits. A true condition writes `next_pc` = `instr_pc` + 2 + displacement.
- R4: Branch with `long_sel` = 1: the displacement is the 32-bit value {`disp_hi`, `disp_lo`}, with the high word first. A true condition writes `instr_pc` + 2 + displacement.
- R5: Branch with a false condition writes `next_pc` = `instr_pc` + 4 when `long_sel` = 0, and `instr_pc` + 6 when `long_sel` = 1.
- R6: Loop with a true condition writes `next_pc` = `instr_pc` + 6 and leaves `cnt_we` low.
- R7: Loop with a false condition raises `cnt_we`. `cnt_out` equals `cnt_in` with bits 15:0 decremented by one modulo 2^16 and bits 31:16 unchanged.
- R8: Loop with a false condition writes `next_pc` = `instr_pc` + 6 if the decremented low word is 0xFFFF. Otherwise it writes `instr_pc` + 2 + sign-extended `disp_hi`.
- R9: The trap mode field selects an operand size: 3'b100 gives 0 bytes, 3'b010 gives 2 bytes and 3'b011 gives 4 bytes. A false condition writes `next_pc` = `instr_pc` + 2 + size.
- R10: Trap with a true condition raises `trap_req`, with `trap_vec` = 7 and `trap_ret_pc` = `instr_pc` + 2 + size. `pc_we` stays low.
- R11: A trap mode other than the three above, or the reserved kind, raises `illegal`, with no PC write, no counter write and no trap.
- R12: With `unord_abort` high, a request raises none of `pc_we`, `cnt_we` or `trap_req`. `illegal` from R11 still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 branch, 1 loop, 2 trap, 3 reserved |
| instr_pc | input | 32 | Address of the operation's first word |
| disp_hi | input | 16 | First displacement word |
| disp_lo | input | 16 | Second displacement word (long branch) |
| long_sel | input | 1 | Branch displacement size: 0 = 16-bit, 1 = 32-bit |
| trap_mode | input | 3 | Trap operand size encoding |
| cnt_in | input | 32 | Current loop counter register |
| cond_true | input | 1 | Predicate outcome |
| unord_abort | input | 1 | Unordered exception taken; suppress updates |
| rsp_valid | output | 1 | Response present |
| pc_we | output | 1 | Write `next_pc` to the program counter |
| next_pc | output | 32 | Resolved program counter |
| cnt_we | output | 1 | Write `cnt_out` to the counter register |
| cnt_out | output | 32 | Updated counter register |
| trap_req | output | 1 | Raise a trap |
| trap_vec | output | 8 | Trap vector number |
| trap_ret_pc | output | 32 | Return address for the trap |
| illegal | output | 1 | Illegal-instruction indication |

## Verification
For a loop with a false condition, the counter decrement and the PC decision are made in the same cycle, and the PC decision depends on the decremented value. The bench provokes this with low words of 0x0000, which wraps to 0xFFFF and falls through, 0x0001, which reaches zero and still branches, and ordinary values, each with nonzero upper bits that must survive. It also sends an unordered abort on top of both an illegal trap mode and a counter decrement, to show which indication wins. Each clock is judged field by field against a behavioural model.

// File: rtl/fpcb_pkg.sv
package fpcb_pkg;
  typedef enum logic [1:0] {
    K_BRANCH = 2'd0,
    K_LOOP   = 2'd1,
    K_TRAP   = 2'd2,
    K_RSVD   = 2'd3
  } flow_kind_e;

  localparam int unsigned TRAP_VECTOR = 7;
endpackage

// File: rtl/fpcb_disp.sv
// Builds a sign-extended displacement from one or two 16-bit words.
module fpcb_disp #(
  parameter int unsigned AW = 32
) (
  input  logic          long_sel,
  input  logic [15:0]   word_a,
  input  logic [15:0]   word_b,
  output logic [AW-1:0] disp
);
  logic [31:0] raw;

  always_comb begin
    if (long_sel) raw = {word_a, word_b};
    else          raw = {{16{word_a[15]}}, word_a};
  end

  generate
    if (AW == 32) begin : g_exact
      assign disp = raw;
    end else begin : g_wide
      assign disp = {{(AW-32){raw[31]}}, raw};
    end
  endgenerate
endmodule

// File: rtl/fpcb_loop.sv
// Decrements the low part of the counter and flags the terminal value.
module fpcb_loop #(
  parameter int unsigned CW = 32,
  parameter int unsigned LW = 16
) (
  input  logic [CW-1:0] cnt_in,
  output logic [CW-1:0] cnt_dec,
  output logic          expired
);
  logic [LW-1:0] low_next;

  assign low_next = cnt_in[LW-1:0] - LW'(1);
  assign expired  = (low_next == {LW{1'b1}});

  generate
    if (CW > LW) begin : g_keep_upper
      assign cnt_dec = {cnt_in[CW-1:LW], low_next};
    end else begin : g_all_low
      assign cnt_dec = low_next;
    end
  endgenerate
endmodule

// File: rtl/fpcb_trapsz.sv
// Decodes the trap operand-size field.
module fpcb_trapsz (
  input  logic [2:0] mode,
  output logic [2:0] size_bytes,
  output logic       legal
);
  always_comb begin
    legal      = 1'b1;
    size_bytes = 3'd0;
    unique case (mode)
      3'b100:  size_bytes = 3'd0;
      3'b010:  size_bytes = 3'd2;
      3'b011:  size_bytes = 3'd4;
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/fp_cond_flow.sv
module fp_cond_flow #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 32,
  parameter int unsigned LW = 16,
  parameter int unsigned VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] instr_pc,
  input  logic [15:0]   disp_hi,
  input  logic [15:0]   disp_lo,
  input  logic          long_sel,
  input  logic [2:0]    trap_mode,
  input  logic [CW-1:0] cnt_in,
  input  logic          cond_true,
  input  logic          unord_abort,
  output logic          rsp_valid,
  output logic          pc_we,
  output logic [AW-1:0] next_pc,
  output logic          cnt_we,
  output logic [CW-1:0] cnt_out,
  output logic          trap_req,
  output logic [VW-1:0] trap_vec,
  output logic [AW-1:0] trap_ret_pc,
  output logic          illegal
);
  import fpcb_pkg::*;

  localparam logic [AW-1:0] OPC_BYTES  = AW'(2);
  localparam logic [AW-1:0] SHORT_SKIP = AW'(2);
  localparam logic [AW-1:0] LONG_SKIP  = AW'(4);
  localparam logic [VW-1:0] VEC_VAL    = VW'(TRAP_VECTOR);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // datapath units
  logic [AW-1:0] br_disp, loop_disp;
  logic [CW-1:0] cnt_dec;
  logic          cnt_expired;
  logic [2:0]    trap_size;
  logic          trap_legal;

  fpcb_disp #(.AW(AW)) u_br_disp (
    .long_sel (long_sel),
    .word_a   (disp_hi),
    .word_b   (disp_lo),
    .disp     (br_disp)
  );

  fpcb_disp #(.AW(AW)) u_loop_disp (
    .long_sel (1'b0),
    .word_a   (disp_hi),
    .word_b   (disp_lo),
    .disp     (loop_disp)
  );

  fpcb_loop #(.CW(CW), .LW(LW)) u_loop (
    .cnt_in  (cnt_in),
    .cnt_dec (cnt_dec),
    .expired (cnt_expired)
  );

  fpcb_trapsz u_trapsz (
    .mode       (trap_mode),
    .size_bytes (trap_size),
    .legal      (trap_legal)
  );

  // next-state
  logic          n_pc_we, n_cnt_we, n_trap, n_illegal;
  logic [AW-1:0] n_next_pc, n_ret_pc, pc_base, trap_next;
  logic [CW-1:0] n_cnt;

  assign pc_base   = instr_pc + OPC_BYTES;
  assign trap_next = pc_base + AW'(trap_size);

  always_comb begin
    n_pc_we   = 1'b0;
    n_cnt_we  = 1'b0;
    n_trap    = 1'b0;
    n_illegal = 1'b0;
    n_next_pc = '0;
    n_ret_pc  = '0;
    n_cnt     = '0;
    if (req_valid) begin
      unique case (flow_kind_e'(req_kind))
        K_BRANCH: begin
          if (!unord_abort) begin
            n_pc_we = 1'b1;
            if (cond_true)     n_next_pc = pc_base + br_disp;
            else if (long_sel) n_next_pc = pc_base + LONG_SKIP;
            else               n_next_pc = pc_base + SHORT_SKIP;
          end
        end
        K_LOOP: begin
          if (!unord_abort) begin
            n_pc_we = 1'b1;
            if (cond_true) begin
              n_next_pc = pc_base + LONG_SKIP;
            end else begin
              n_cnt_we  = 1'b1;
              n_cnt     = cnt_dec;
              n_next_pc = cnt_expired ? (pc_base + LONG_SKIP)
                                      : (pc_base + loop_disp);
            end
          end
        end
        K_TRAP: begin
          if (!trap_legal) begin
            n_illegal = 1'b1;
          end else if (!unord_abort) begin
            if (cond_true) begin
              n_trap   = 1'b1;
              n_ret_pc = trap_next;
            end else begin
              n_pc_we   = 1'b1;
              n_next_pc = trap_next;
            end
          end
        end
        default: n_illegal = 1'b1;
      endcase
    end
  end

  // registers
  logic load_en;
  assign load_en = req_valid | rsp_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid   <= 1'b0;
      pc_we       <= 1'b0;
      next_pc     <= '0;
      cnt_we      <= 1'b0;
      cnt_out     <= '0;
      trap_req    <= 1'b0;
      trap_vec    <= '0;
      trap_ret_pc <= '0;
      illegal     <= 1'b0;
    end else if (load_en) begin
      rsp_valid   <= req_valid;
      pc_we       <= n_pc_we;
      next_pc     <= n_next_pc;
      cnt_we      <= n_cnt_we;
      cnt_out     <= n_cnt;
      trap_req    <= n_trap;
      trap_vec    <= n_trap ? VEC_VAL : '0;
      trap_ret_pc <= n_ret_pc;
      illegal     <= n_illegal;
    end
  end
endmodule

// File: rtl/fp_cond_flow_chk.sv
module fp_cond_flow_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 32,
  parameter int unsigned LW = 16,
  parameter int unsigned VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_kind,
  input logic [CW-1:0] cnt_in,
  input logic          cond_true,
  input logic          unord_abort,
  input logic          rsp_valid,
  input logic          pc_we,
  input logic          cnt_we,
  input logic [CW-1:0] cnt_out,
  input logic          trap_req,
  input logic [VW-1:0] trap_vec,
  input logic          illegal
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(pc_we || cnt_we || trap_req || illegal));

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_loop_true_keeps_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1 && cond_true) |=> !cnt_we);

  p_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1 && !cond_true && !unord_abort) |=>
      (cnt_we && cnt_out[CW-1:LW] == $past(cnt_in[CW-1:LW])));

  p_trap_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (!pc_we && trap_vec == VW'(7)));

  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !(pc_we || cnt_we || trap_req));

  p_abort_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && unord_abort) |=> !(pc_we || cnt_we || trap_req));
endmodule

bind fp_cond_flow fp_cond_flow_chk #(.AW(AW), .CW(CW), .LW(LW), .VW(VW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req_valid   (req_valid),
  .req_kind    (req_kind),
  .cnt_in      (cnt_in),
  .cond_true   (cond_true),
  .unord_abort (unord_abort),
  .rsp_valid   (rsp_valid),
  .pc_we       (pc_we),
  .cnt_we      (cnt_we),
  .cnt_out     (cnt_out),
  .trap_req    (trap_req),
  .trap_vec    (trap_vec),
  .illegal     (illegal)
);

// File: tb/fp_cond_flow_tb_top.sv
module fp_cond_flow_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [31:0] instr_pc;
  logic [15:0] disp_hi, disp_lo;
  logic        long_sel;
  logic [2:0]  trap_mode;
  logic [31:0] cnt_in;
  logic        cond_true, unord_abort;
  logic        rsp_valid, pc_we, cnt_we, trap_req, illegal;
  logic [31:0] next_pc, cnt_out, trap_ret_pc;
  logic [7:0]  trap_vec;

  int checks = 0;
  int errors = 0;

  // expected response for the request driven in the previous cycle
  logic        e_valid, e_pc_we, e_cnt_we, e_trap, e_illegal;
  logic [31:0] e_next_pc, e_cnt, e_ret;
  string       e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_cond_flow dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .instr_pc(instr_pc), .disp_hi(disp_hi), .disp_lo(disp_lo),
    .long_sel(long_sel), .trap_mode(trap_mode), .cnt_in(cnt_in),
    .cond_true(cond_true), .unord_abort(unord_abort),
    .rsp_valid(rsp_valid), .pc_we(pc_we), .next_pc(next_pc),
    .cnt_we(cnt_we), .cnt_out(cnt_out), .trap_req(trap_req),
    .trap_vec(trap_vec), .trap_ret_pc(trap_ret_pc), .illegal(illegal)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2", "rsp_valid", 32'(rsp_valid), 32'(e_valid));
    chk(e_tag, "pc_we", 32'(pc_we), 32'(e_pc_we));
    if (e_pc_we) chk(e_tag, "next_pc", next_pc, e_next_pc);
    chk(e_tag, "cnt_we", 32'(cnt_we), 32'(e_cnt_we));
    if (e_cnt_we) chk(e_tag, "cnt_out", cnt_out, e_cnt);
    chk(e_tag, "trap_req", 32'(trap_req), 32'(e_trap));
    if (e_trap) begin
      chk(e_tag, "trap_vec", 32'(trap_vec), 32'd7);
      chk(e_tag, "trap_ret_pc", trap_ret_pc, e_ret);
    end
    chk(e_tag, "illegal", 32'(illegal), 32'(e_illegal));
  endtask

  // behavioural reference for the request currently on the inputs
  task automatic model();
    logic [31:0] base, sx, lng;
    logic [15:0] low;
    int sz;
    base = instr_pc + 32'd2;
    sx   = {{16{disp_hi[15]}}, disp_hi};
    lng  = {disp_hi, disp_lo};
    e_valid = req_valid; e_pc_we = 0; e_cnt_we = 0; e_trap = 0; e_illegal = 0;
    e_next_pc = 0; e_cnt = 0; e_ret = 0; e_tag = "R1";
    if (req_valid) begin
      case (req_kind)
        2'd0: begin
          e_tag = cond_true ? (long_sel ? "R4" : "R3") : "R5";
          e_pc_we = 1;
          if (cond_true) e_next_pc = base + (long_sel ? lng : sx);
          else           e_next_pc = base + (long_sel ? 32'd4 : 32'd2);
        end
        2'd1: begin
          e_pc_we = 1;
          if (cond_true) begin
            e_tag = "R6"; e_next_pc = base + 32'd4;
          end else begin
            e_tag = "R8";
            low = cnt_in[15:0] - 16'd1;
            e_cnt_we = 1; e_cnt = {cnt_in[31:16], low};
            e_next_pc = (low == 16'hFFFF) ? base + 32'd4 : base + sx;
          end
        end
        2'd2: begin
          sz = -1;
          if (trap_mode == 3'b100) sz = 0;
          if (trap_mode == 3'b010) sz = 2;
          if (trap_mode == 3'b011) sz = 4;
          if (sz < 0) begin
            e_tag = "R11"; e_illegal = 1;
          end else if (cond_true) begin
            e_tag = "R10"; e_trap = 1; e_ret = base + 32'(sz);
          end else begin
            e_tag = "R9"; e_pc_we = 1; e_next_pc = base + 32'(sz);
          end
        end
        default: begin e_tag = "R11"; e_illegal = 1; end
      endcase
      if (unord_abort && !e_illegal) begin
        e_tag = "R12"; e_pc_we = 0; e_cnt_we = 0; e_trap = 0;
      end
    end
  endtask

  // one clock: judge the last response, then present the next request
  task automatic step(input logic v, input logic [1:0] k, input logic [31:0] pc,
                      input logic [15:0] h, input logic [15:0] l, input logic ls,
                      input logic [2:0] m, input logic [31:0] c,
                      input logic ct, input logic ab);
    @(negedge clk);
    compare();
    req_valid = v; req_kind = k; instr_pc = pc; disp_hi = h; disp_lo = l;
    long_sel = ls; trap_mode = m; cnt_in = c; cond_true = ct; unord_abort = ab;
    model();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_kind = 0; instr_pc = 0; disp_hi = 0; disp_lo = 0;
    long_sel = 0; trap_mode = 0; cnt_in = 0; cond_true = 0; unord_abort = 0;
    model();
    repeat (3) @(negedge clk);
    compare();  // R1: quiet under reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 short taken, negative displacement
    step(1, 0, 32'h0000_1000, 16'hFFF0, 16'h0000, 0, 0, 0, 1, 0);
    // R4 long taken
    step(1, 0, 32'h0000_2000, 16'h0001, 16'h0234, 1, 0, 0, 1, 0);
    // R5 not taken, both sizes
    step(1, 0, 32'h0000_3000, 16'h7777, 16'h1111, 0, 0, 0, 0, 0);
    step(1, 0, 32'h0000_3000, 16'h7777, 16'h1111, 1, 0, 0, 0, 0);
    // R6 loop true
    step(1, 1, 32'h0000_4000, 16'h0010, 0, 0, 0, 32'hABCD_0005, 1, 0);
    // R7 R8 loop false: normal, wrap, reach zero
    step(1, 1, 32'h0000_5000, 16'hFFFC, 0, 0, 0, 32'h1234_0005, 0, 0);
    step(1, 1, 32'h0000_5000, 16'hFFFC, 0, 0, 0, 32'hABCD_0000, 0, 0);
    step(1, 1, 32'h0000_5000, 16'h0020, 0, 0, 0, 32'h8000_0001, 0, 0);
    // R9 R10 each trap mode, both outcomes
    step(1, 2, 32'h0000_6000, 0, 0, 0, 3'b100, 0, 0, 0);
    step(1, 2, 32'h0000_6000, 0, 0, 0, 3'b010, 0, 0, 0);
    step(1, 2, 32'h0000_6000, 0, 0, 0, 3'b011, 0, 0, 0);
    step(1, 2, 32'h0000_6000, 0, 0, 0, 3'b100, 0, 1, 0);
    step(1, 2, 32'h0000_6000, 0, 0, 0, 3'b011, 0, 1, 0);
    // R11 bad modes and reserved kind
    step(1, 2, 32'h0000_7000, 0, 0, 0, 3'b000, 0, 1, 0);
    step(1, 2, 32'h0000_7000, 0, 0, 0, 3'b111, 0, 0, 0);
    step(1, 3, 32'h0000_7000, 0, 0, 0, 3'b100, 0, 1, 0);
    // R12 abort on every kind, incl. counter decrement and bad mode
    step(1, 0, 32'h0000_8000, 16'h0040, 0, 0, 0, 0, 1, 1);
    step(1, 1, 32'h0000_8000, 16'h0040, 0, 0, 0, 32'h5555_0000, 0, 1);
    step(1, 2, 32'h0000_8000, 0, 0, 0, 3'b010, 0, 1, 1);
    step(1, 2, 32'h0000_8000, 0, 0, 0, 3'b110, 0, 1, 1);
    // R1 idle gap
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 32'h1, 16'h1, 0, 0, 0, 32'h0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      step(1'($urandom_range(0, 7) != 0), 2'($urandom), $urandom, 16'($urandom),
           16'($urandom), 1'($urandom), 3'($urandom),
           {16'($urandom), 16'($urandom_range(0, 3))},
           1'($urandom), 1'($urandom_range(0, 5) == 0));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule